// File: doc/BRIEF.md
# Three-Wire Serial Synthesiser Control Register

This block takes a programming word from a three-line serial bus (data, clock, enable) and holds the decoded control fields for a PLL frequency synthesiser. The three bus lines are asynchronous to the block's system clock. Each line passes through a two-flop synchroniser, and bus clock and enable edges are detected on the synchronised copies. While enable is high, every rising bus clock shifts one data bit into a shift register, most significant bit first. When enable falls, the block checks the bit count. A word of exactly the configured length moves into a staging register. A word of any other length is dropped, and a sticky error flag is raised.

A word held in staging does not reach the outputs at once. It waits for a one-cycle pulse from the feedback divider that marks the end of a divider cycle. On that pulse the whole word moves into the output register in a single step, so that a retune never lands in the middle of a divide cycle. If more than one word arrives before the pulse, the most recent one is applied. A parameter selects the long word of 28 bits with four port bits, or the short word of 26 bits with two port bits. These control pins have no handshake: the bus has no back-pressure, and the divider pulse paces every update.

Top module: `tw_ctrl_reg`

## Requirements
- R1: Rising bus clock edges while enable is low shift nothing and do not count towards the word length.
- R2: While enable is high, each rising bus clock shifts in the data bit, and the first bit sent becomes the most significant bit of the word.
- R3: The long word (LONG_WORD=1, 28 bits) is laid out as follows. Bit 0 is the prescaler enable. Bits 17:1 are the divider ratio. Bits 20:18 are the reference select. Bit 21 is the charge-pump current select. Bit 22 is the drive disable. Bit 23 is the test enable. Bits 27:24 are the port bits.
- R4: The short word (LONG_WORD=0, 26 bits) keeps every lower field of R3 in the same bit position and carries only two port bits, in bits 25:24.
- R5: On a falling edge of enable, the word is accepted only if exactly the configured number of bits has been shifted since enable rose. Otherwise the word is discarded, and the outputs keep their previous values.
- R6: An accepted word appears on the outputs in the cycle after the first divider-wrap pulse that follows its acceptance. The outputs do not change at any other time.
- R7: If several words are accepted before a divider-wrap pulse, the pulse applies only the last of them.
- R8: After reset, all outputs are zero: ports off, prescaler disabled, ratio zero, normal mode, no error.
- R9: A word of the wrong length sets frame_err, and frame_err stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk | input | 1 | Serial bus clock, asynchronous |
| bus_data | input | 1 | Serial bus data, asynchronous |
| bus_en | input | 1 | Serial bus enable, asynchronous |
| div_wrap | input | 1 | One-cycle pulse at the end of a feedback divider cycle |
| div_ratio | output | 17 | Programmable divider ratio |
| presc_en | output | 1 | Divide-by-two prescaler enable |
| ref_sel | output | 3 | Reference divider select |
| cp_hi | output | 1 | Charge-pump high-current select |
| drive_off | output | 1 | Varactor drive disable |
| test_en | output | 1 | Test mode enable |
| port_bits | output | NPORT | Switching port bits (4 or 2) |
| frame_err | output | 1 | Sticky flag for a word of the wrong length |

## Verification
The hardest case to reach is the window between acceptance and the divider pulse. During that window the new word is held but must not be visible. The bench holds div_wrap low for many cycles after each frame and checks that the outputs still show the old word. It then sends a second word before any pulse, so that one pulse has to apply only the later word. Stray bus clocks with enable low, frames that are short or long by one bit, and a second instance built for the short word complete the sweep.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned LONG_BITS  = 28;
  localparam int unsigned SHORT_BITS = 26;

  // Bit order matches the serial word, MSB first
  typedef struct packed {
    logic [3:0]  port;
    logic        test;
    logic        drv_off;
    logic        cp_hi;
    logic [2:0]  ref_sel;
    logic [16:0] ratio;
    logic        presc;
  } ctrl_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned N      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
  parameter int unsigned W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_clk,
  input  logic         s_data,
  input  logic         s_en,
  output logic         word_ok,
  output logic         word_bad,
  output logic [W-1:0] word
);
  localparam int unsigned CNT_W = $clog2(W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(W + 1);

  logic             clk_q, en_q;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     sr;
  logic             clk_rise, en_fall;

  assign clk_rise = s_clk & ~clk_q;
  assign en_fall  = ~s_en & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      clk_q <= s_clk;
      en_q  <= s_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (en_fall) begin
      cnt <= '0;
    end else if (s_en && clk_rise) begin
      sr  <= {sr[W-2:0], s_data};
      if (cnt != OVER) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_ok  <= 1'b0;
      word_bad <= 1'b0;
      word     <= '0;
    end else begin
      word_ok  <= en_fall && (cnt == FULL);
      word_bad <= en_fall && (cnt != FULL);
      if (en_fall) word <= sr;
    end
  end

  // R1
  idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_en && !en_q) |-> (cnt == '0));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= OVER);

  // R5
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_ok && word_bad));
endmodule

// File: rtl/tw_commit.sv
module tw_commit
  import tw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  word_ok,
  input  ctrl_t word_in,
  input  logic  div_wrap,
  output ctrl_t ctrl
);
  ctrl_t stage;
  logic  pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      pend  <= 1'b0;
      ctrl  <= '0;
    end else if (word_ok) begin
      stage <= word_in;
      pend  <= 1'b1;
    end else if (pend && div_wrap) begin
      ctrl  <= stage;
      pend  <= 1'b0;
    end
  end

  // R6
  hold_between_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_wrap |=> $stable(ctrl));

  // R6
  idle_no_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !word_ok) |=> $stable(ctrl));
endmodule

// File: rtl/tw_ctrl_reg.sv
module tw_ctrl_reg
  import tw_pkg::*;
#(
  parameter bit          LONG_WORD = 1'b1,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned W     = LONG_WORD ? LONG_BITS : SHORT_BITS,
  localparam int unsigned NPORT = W - 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_clk,
  input  logic             bus_data,
  input  logic             bus_en,
  input  logic             div_wrap,
  output logic [16:0]      div_ratio,
  output logic             presc_en,
  output logic [2:0]       ref_sel,
  output logic             cp_hi,
  output logic             drive_off,
  output logic             test_en,
  output logic [NPORT-1:0] port_bits,
  output logic             frame_err
);
  logic [2:0]   s_bus;
  logic         word_ok, word_bad;
  logic [W-1:0] word;
  ctrl_t        word_full, ctrl;
  logic         err_q;

  tw_sync #(.STAGES(SYNC_STAGES), .N(3)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({bus_en, bus_data, bus_clk}),
    .q(s_bus)
  );

  tw_shifter #(.W(W)) shift_i (
    .clk(clk), .rst_n(rst_n),
    .s_clk(s_bus[0]), .s_data(s_bus[1]), .s_en(s_bus[2]),
    .word_ok(word_ok), .word_bad(word_bad), .word(word)
  );

  generate
    if (W == LONG_BITS) begin : g_long
      assign word_full = ctrl_t'(word);
    end else begin : g_short
      assign word_full = ctrl_t'({{(LONG_BITS - W){1'b0}}, word});
    end
  endgenerate

  tw_commit commit_i (
    .clk(clk), .rst_n(rst_n),
    .word_ok(word_ok), .word_in(word_full),
    .div_wrap(div_wrap), .ctrl(ctrl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (word_bad) err_q <= 1'b1;
  end

  assign div_ratio = ctrl.ratio;
  assign presc_en  = ctrl.presc;
  assign ref_sel   = ctrl.ref_sel;
  assign cp_hi     = ctrl.cp_hi;
  assign drive_off = ctrl.drv_off;
  assign test_en   = ctrl.test;
  assign port_bits = ctrl.port[NPORT-1:0];
  assign frame_err = err_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
endmodule

// File: tb/tw_ctrl_reg_tb_top.sv
module tw_ctrl_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0, bus_data = 1'b0, bus_en = 1'b0, div_wrap = 1'b0;

  logic [16:0] l_ratio, s_ratio;
  logic        l_presc, s_presc, l_cp, s_cp, l_drv, s_drv, l_test, s_test, l_err, s_err;
  logic [2:0]  l_ref, s_ref;
  logic [3:0]  l_port;
  logic [1:0]  s_port;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tw_ctrl_reg #(.LONG_WORD(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
    .bus_en(bus_en), .div_wrap(div_wrap), .div_ratio(l_ratio),
    .presc_en(l_presc), .ref_sel(l_ref), .cp_hi(l_cp), .drive_off(l_drv),
    .test_en(l_test), .port_bits(l_port), .frame_err(l_err));

  tw_ctrl_reg #(.LONG_WORD(1'b0)) short_i (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
    .bus_en(bus_en), .div_wrap(div_wrap), .div_ratio(s_ratio),
    .presc_en(s_presc), .ref_sel(s_ref), .cp_hi(s_cp), .drive_off(s_drv),
    .test_en(s_test), .port_bits(s_port), .frame_err(s_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Long-instance output vector rebuilt in the word layout of R3
  function automatic logic [31:0] long_now();
    return {4'h0, l_port, l_test, l_drv, l_cp, l_ref, l_ratio, l_presc};
  endfunction

  function automatic logic [31:0] short_now();
    return {6'h0, s_port, s_test, s_drv, s_cp, s_ref, s_ratio, s_presc};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w, input int nbits);
    bus_en = 1'b1;
    wait_cyc(4);
    for (int b = nbits - 1; b >= 0; b--) begin
      bus_data = w[b];
      wait_cyc(4);
      bus_clk = 1'b1;
      wait_cyc(4);
      bus_clk = 1'b0;
      wait_cyc(3);
    end
    bus_en = 1'b0;
    wait_cyc(8);
  endtask

  task automatic stray(input int n);
    for (int k = 0; k < n; k++) begin
      bus_data = k[0];
      wait_cyc(4);
      bus_clk = 1'b1;
      wait_cyc(4);
      bus_clk = 1'b0;
      wait_cyc(3);
    end
  endtask

  task automatic wrap();
    div_wrap = 1'b1;
    wait_cyc(1);
    div_wrap = 1'b0;
    wait_cyc(2);
  endtask

  logic [31:0] cur;

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [31:0] w2;
    wait_cyc(3);
    // R8: reset state
    chk("R8 reset outputs", long_now(), 32'h0);
    chk("R8 reset error", {31'h0, l_err}, 32'h0);
    rst_n = 1'b1;
    wait_cyc(3);
    chk("R8 after release", long_now(), 32'h0);
    cur = 32'h0;

    // wrap with nothing pending changes nothing (R6)
    wrap();
    chk("R6 idle wrap", long_now(), cur);

    // Corner words and an arithmetic sweep (R2, R3, R6)
    for (int i = 0; i < 26; i++) begin
      if (i == 0) w = 32'h0FFFFFFF;
      else if (i == 1) w = 32'h00000001;
      else if (i == 2) w = 32'h08000000;
      else w = ((i * 32'h02F1B3D7) ^ (32'h01234567 + (i << 5))) & 32'h0FFFFFFF;
      if (i[0]) stray(3);           // R1: clocks with enable low are ignored
      send(w, 28);
      wait_cyc(20);
      chk("R6 held before wrap", long_now(), cur);
      wrap();
      cur = w;
      chk(i[0] ? "R1 R3 decode after stray clocks" : "R2 R3 decode", long_now(), cur);
      chk("R3 ratio field", {15'h0, l_ratio}, (w >> 1) & 32'h1FFFF);
      chk("R3 ref field", {29'h0, l_ref}, (w >> 18) & 32'h7);
      chk("R9 no error on good words", {31'h0, l_err}, 32'h0);
    end

    // R7: two words before one wrap
    w  = 32'h0A5A5A5A;
    w2 = 32'h05C3C3C3;
    send(w, 28);
    send(w2, 28);
    chk("R7 held with two pending", long_now(), cur);
    wrap();
    cur = w2;
    chk("R7 last word wins", long_now(), cur);
    wrap();
    chk("R7 second wrap no change", long_now(), cur);

    // R5, R9: short by one bit
    send(32'h0F0F0F0F, 27);
    chk("R9 error after short word", {31'h0, l_err}, 32'h1);
    wrap();
    chk("R5 short word discarded", long_now(), cur);
    // long by one bit
    send(32'h1F0F0F0F, 29);
    wrap();
    chk("R5 long word discarded", long_now(), cur);
    // good word afterwards still applies, error stays set
    w = 32'h0135_7531;
    send(w, 28);
    wrap();
    cur = w;
    chk("R5 good word after bad", long_now(), cur);
    chk("R9 error sticky", {31'h0, l_err}, 32'h1);

    // R4: short-word instance
    for (int j = 0; j < 4; j++) begin
      w = ((j * 32'h00B7A5C3) ^ 32'h02AC_3E51) & 32'h03FFFFFF;
      send(w, 26);
      wrap();
      chk("R4 short layout", short_now(), w);
      chk("R4 short ports", {30'h0, s_port}, (w >> 24) & 32'h3);
    end
    chk("R5 long instance rejects short frames", long_now(), cur);

    // R8: reset clears error and outputs
    rst_n = 1'b0;
    wait_cyc(2);
    chk("R8 reset clears outputs", long_now(), 32'h0);
    chk("R8 reset clears error", {31'h0, l_err}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule